// File: doc/BRIEF.md
# Microcode Sequencer Control Unit

This block produces every control point for a small multicycle 32-bit load/store datapath. It uses no hand-built state machine. A micro-program counter selects one word of a microcode store. Each word carries two things. The first is an encoded value for each control group: ALU operation, first operand, second operand, register destination, memory access, instruction-register load and PC update. The second is a sequencing code that picks the next micro-address. Small field decoders expand the encoded groups into the individual control lines.

After reset the sequencer sits on the fetch step. The second step reads registers and forms a branch target. It then jumps through an opcode-indexed dispatch table to the first step of the instruction's class. Five classes are supported: register-register ALU, load, store, branch-if-equal and OR-immediate. Each class's last step returns to fetch. The opcode values are parameters. An opcode that matches no class goes straight back to fetch.

Top module: `ucode_ctrl`

## Requirements
- R1: While reset is asserted, the micro-address is 0 and the outputs hold the fetch step's controls.
- R2: At micro-address 0, the outputs are: mem_rd=1, iord=0, ir_wr=1, pc_wr=1, pc_src=0, pc_load=1, alu_op=00 (add), alu_sel_a=0 (PC) and alu_sel_b=00 (constant 4). The next micro-address is 1.
- R3: At micro-address 1, the outputs are alu_op=00, alu_sel_a=0, alu_sel_b=10 (immediate shifted left 2) and ext_signed=1, with no state write. The next micro-address comes from the opcode: register-register goes to 7, load to 2, store to 5, branch-equal to 9 and OR-immediate to 10.
- R4: An opcode that matches no class makes micro-address 1 go next to address 0.
- R5: The load class runs three steps. Address 2 does an add with alu_sel_a=1 (rs), alu_sel_b=11 (extended immediate) and ext_signed=1. Address 3 sets mem_rd=1 with iord=1. Address 4 sets reg_wr=1 with reg_dst=0 and mem_to_reg=1. The sequencer then returns to 0.
- R6: The store class runs two steps. Address 5 does the same address add as address 2. Address 6 sets mem_wr=1 with iord=1. The sequencer then returns to 0.
- R7: The register-register class runs two steps. Address 7 sets alu_op=10 (function code), alu_sel_a=1 and alu_sel_b=01 (rt). Address 8 sets reg_wr=1, reg_dst=1 and mem_to_reg=0. The sequencer then returns to 0.
- R8: The branch class is one step, at address 9. It sets alu_op=01 (subtract), alu_sel_a=1, alu_sel_b=01, pc_wr_cond=1 and pc_src=1 (ALU output register). At that step pc_load follows alu_zero. The sequencer then returns to 0.
- R9: The OR-immediate class runs two steps. Address 10 sets alu_op=11 (OR), alu_sel_a=1, alu_sel_b=11 and ext_signed=0 (zero extend). Address 11 sets reg_wr=1, reg_dst=0 and mem_to_reg=0. The sequencer then returns to 0.
- R10: A control group left blank in a step drives all of its lines to 0. mem_rd and mem_wr are never both set. pc_load is set only by an unconditional PC write, or by a conditional write while alu_zero is 1; alu_zero has no effect at any other step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPW | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag from the datapath |
| upc | output | UPC_W | Current micro-address |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function code, 11 OR |
| alu_sel_a | output | 1 | First operand: 0 PC, 1 rs register |
| alu_sel_b | output | 2 | Second operand: 00 constant 4, 01 rt, 10 immediate shifted by 2, 11 immediate |
| ext_signed | output | 1 | Immediate extension: 1 sign, 0 zero |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| iord | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr | output | 1 | Load instruction register |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Write register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALU output, 1 memory data |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the zero flag is set |
| pc_src | output | 1 | Next PC: 0 ALU result, 1 ALU output register |
| pc_load | output | 1 | Effective PC load enable |

## Verification
The properties check on every clock the parts of the sequencing that hold whatever the opcode:
- fetch always leads to address 1;
- the dispatch target follows the opcode, and unknown opcodes fall back to fetch;
- each class's last step returns to 0;
- reads and writes never overlap;
- register writes never coincide with fetch;
- at the branch step, pc_load equals the zero flag.

Only the bench's scenarios can show that each class's steps, taken in order, present the exact field values in the exact cycle. They also show that the zero flag is ignored outside the branch step, and that opcodes applied in sequence each run their full step list.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

   typedef enum logic [2:0] {ALU_NONE, ALU_ADD, ALU_SUB, ALU_FUNC, ALU_OR} alu_f_t;
   typedef enum logic [1:0] {S1_NONE, S1_PC, S1_RS} src1_f_t;
   typedef enum logic [2:0] {S2_NONE, S2_FOUR, S2_RT, S2_IMM_SH, S2_IMM_S, S2_IMM_Z} src2_f_t;
   typedef enum logic [1:0] {DST_NONE, DST_RD_ALU, DST_RT_ALU, DST_RT_MEM} dst_f_t;
   typedef enum logic [1:0] {MEM_NONE, MEM_RD_PC, MEM_RD_ALU, MEM_WR_ALU} mem_f_t;
   typedef enum logic [0:0] {MR_NONE, MR_IR} mreg_f_t;
   typedef enum logic [1:0] {PCW_NONE, PCW_ALU, PCW_COND_OUT} pcw_f_t;
   typedef enum logic [1:0] {SQ_NEXT, SQ_FETCH, SQ_DISPATCH} seq_f_t;

   typedef struct packed {
      alu_f_t  alu;
      src1_f_t src1;
      src2_f_t src2;
      dst_f_t  dst;
      mem_f_t  mem;
      mreg_f_t mreg;
      pcw_f_t  pcw;
      seq_f_t  seq;
   } uword_t;

   typedef struct packed {
      logic [1:0] alu_op;
      logic       alu_sel_a;
      logic [1:0] alu_sel_b;
      logic       ext_signed;
      logic       mem_rd;
      logic       mem_wr;
      logic       iord;
      logic       ir_wr;
      logic       reg_wr;
      logic       reg_dst;
      logic       mem_to_reg;
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       pc_src;
   } ctrl_t;

   // entry micro-addresses of the instruction classes
   localparam int unsigned UA_FETCH  = 0;
   localparam int unsigned UA_DECODE = 1;
   localparam int unsigned UA_LOAD   = 2;
   localparam int unsigned UA_STORE  = 5;
   localparam int unsigned UA_RR     = 7;
   localparam int unsigned UA_BEQ    = 9;
   localparam int unsigned UA_ORI    = 10;
   localparam int unsigned UA_LAST   = 11;
   localparam int unsigned NCLS      = 5;

   function automatic uword_t mk_uword(alu_f_t a, src1_f_t s1, src2_f_t s2, dst_f_t d,
                                       mem_f_t m, mreg_f_t r, pcw_f_t p, seq_f_t q);
      uword_t w;
      w.alu  = a;
      w.src1 = s1;
      w.src2 = s2;
      w.dst  = d;
      w.mem  = m;
      w.mreg = r;
      w.pcw  = p;
      w.seq  = q;
      return w;
   endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_pkg::*;
#(
   parameter int unsigned UPC_W = 4
) (
   input  logic [UPC_W-1:0] addr,
   output uword_t           word
);

   always_comb begin
      case (int'(addr))
         0:  word = mk_uword(ALU_ADD,  S1_PC,   S2_FOUR,   DST_NONE,   MEM_RD_PC,  MR_IR,   PCW_ALU,      SQ_NEXT);
         1:  word = mk_uword(ALU_ADD,  S1_PC,   S2_IMM_SH, DST_NONE,   MEM_NONE,   MR_NONE, PCW_NONE,     SQ_DISPATCH);
         2:  word = mk_uword(ALU_ADD,  S1_RS,   S2_IMM_S,  DST_NONE,   MEM_NONE,   MR_NONE, PCW_NONE,     SQ_NEXT);
         3:  word = mk_uword(ALU_NONE, S1_NONE, S2_NONE,   DST_NONE,   MEM_RD_ALU, MR_NONE, PCW_NONE,     SQ_NEXT);
         4:  word = mk_uword(ALU_NONE, S1_NONE, S2_NONE,   DST_RT_MEM, MEM_NONE,   MR_NONE, PCW_NONE,     SQ_FETCH);
         5:  word = mk_uword(ALU_ADD,  S1_RS,   S2_IMM_S,  DST_NONE,   MEM_NONE,   MR_NONE, PCW_NONE,     SQ_NEXT);
         6:  word = mk_uword(ALU_NONE, S1_NONE, S2_NONE,   DST_NONE,   MEM_WR_ALU, MR_NONE, PCW_NONE,     SQ_FETCH);
         7:  word = mk_uword(ALU_FUNC, S1_RS,   S2_RT,     DST_NONE,   MEM_NONE,   MR_NONE, PCW_NONE,     SQ_NEXT);
         8:  word = mk_uword(ALU_NONE, S1_NONE, S2_NONE,   DST_RD_ALU, MEM_NONE,   MR_NONE, PCW_NONE,     SQ_FETCH);
         9:  word = mk_uword(ALU_SUB,  S1_RS,   S2_RT,     DST_NONE,   MEM_NONE,   MR_NONE, PCW_COND_OUT, SQ_FETCH);
         10: word = mk_uword(ALU_OR,   S1_RS,   S2_IMM_Z,  DST_NONE,   MEM_NONE,   MR_NONE, PCW_NONE,     SQ_NEXT);
         11: word = mk_uword(ALU_NONE, S1_NONE, S2_NONE,   DST_RT_ALU, MEM_NONE,   MR_NONE, PCW_NONE,     SQ_FETCH);
         default: word = mk_uword(ALU_NONE, S1_NONE, S2_NONE, DST_NONE, MEM_NONE, MR_NONE, PCW_NONE, SQ_FETCH);
      endcase
   end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
   import ucode_pkg::*;
#(
   parameter int unsigned      OPW     = 6,
   parameter int unsigned      UPC_W   = 4,
   parameter logic [OPW-1:0]   OP_RR   = 6'h00,
   parameter logic [OPW-1:0]   OP_LOAD = 6'h23,
   parameter logic [OPW-1:0]   OP_STOR = 6'h2b,
   parameter logic [OPW-1:0]   OP_BEQ  = 6'h04,
   parameter logic [OPW-1:0]   OP_ORI  = 6'h0d
) (
   input  logic [OPW-1:0]   opcode,
   output logic [UPC_W-1:0] target
);

   localparam logic [NCLS*OPW-1:0] OPS = {OP_ORI, OP_BEQ, OP_STOR, OP_LOAD, OP_RR};
   localparam logic [NCLS*UPC_W-1:0] TGT = {
      UPC_W'(UA_ORI), UPC_W'(UA_BEQ), UPC_W'(UA_STORE), UPC_W'(UA_LOAD), UPC_W'(UA_RR)};

   logic [NCLS-1:0] hit;

   for (genvar i = 0; i < NCLS; i++) begin : g_cls
      assign hit[i] = (opcode == OPS[i*OPW +: OPW]);
      for (genvar j = i + 1; j < NCLS; j++) begin : g_uniq
         if (OPS[i*OPW +: OPW] == OPS[j*OPW +: OPW]) begin : g_dup
            $error("ucode_dispatch: two classes share one opcode");
         end
      end
   end

   // classes are distinct, so at most one hit; no match leaves fetch (0)
   always_comb begin
      target = '0;
      for (int i = 0; i < NCLS; i++) begin
         if (hit[i]) target = target | TGT[i*UPC_W +: UPC_W];
      end
   end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int unsigned UPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_f_t           seq,
   input  logic [UPC_W-1:0] dsp_target,
   output logic [UPC_W-1:0] upc
);

   logic [UPC_W-1:0] upc_nxt;

   always_comb begin
      case (seq)
         SQ_NEXT:     upc_nxt = upc + UPC_W'(1);
         SQ_DISPATCH: upc_nxt = dsp_target;
         default:     upc_nxt = UPC_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= UPC_W'(UA_FETCH);
      else        upc <= upc_nxt;
   end

endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
   import ucode_pkg::*;
(
   input  uword_t word,
   output ctrl_t  ctrl
);

   always_comb begin
      ctrl = '0;
      case (word.alu)
         ALU_SUB:  ctrl.alu_op = 2'b01;
         ALU_FUNC: ctrl.alu_op = 2'b10;
         ALU_OR:   ctrl.alu_op = 2'b11;
         default:  ctrl.alu_op = 2'b00;
      endcase
      ctrl.alu_sel_a = (word.src1 == S1_RS);
      case (word.src2)
         S2_RT:     ctrl.alu_sel_b = 2'b01;
         S2_IMM_SH: begin ctrl.alu_sel_b = 2'b10; ctrl.ext_signed = 1'b1; end
         S2_IMM_S:  begin ctrl.alu_sel_b = 2'b11; ctrl.ext_signed = 1'b1; end
         S2_IMM_Z:  ctrl.alu_sel_b = 2'b11;
         default:   ctrl.alu_sel_b = 2'b00;
      endcase
      case (word.dst)
         DST_RD_ALU: begin ctrl.reg_wr = 1'b1; ctrl.reg_dst = 1'b1; end
         DST_RT_ALU: ctrl.reg_wr = 1'b1;
         DST_RT_MEM: begin ctrl.reg_wr = 1'b1; ctrl.mem_to_reg = 1'b1; end
         default: ;
      endcase
      case (word.mem)
         MEM_RD_PC:  ctrl.mem_rd = 1'b1;
         MEM_RD_ALU: begin ctrl.mem_rd = 1'b1; ctrl.iord = 1'b1; end
         MEM_WR_ALU: begin ctrl.mem_wr = 1'b1; ctrl.iord = 1'b1; end
         default: ;
      endcase
      ctrl.ir_wr = (word.mreg == MR_IR);
      case (word.pcw)
         PCW_ALU:      ctrl.pc_wr = 1'b1;
         PCW_COND_OUT: begin ctrl.pc_wr_cond = 1'b1; ctrl.pc_src = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
   import ucode_pkg::*;
#(
   parameter int unsigned    OPW     = 6,
   parameter int unsigned    UPC_W   = 4,
   parameter logic [OPW-1:0] OP_RR   = 6'h00,
   parameter logic [OPW-1:0] OP_LOAD = 6'h23,
   parameter logic [OPW-1:0] OP_STOR = 6'h2b,
   parameter logic [OPW-1:0] OP_BEQ  = 6'h04,
   parameter logic [OPW-1:0] OP_ORI  = 6'h0d
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPW-1:0]   opcode,
   input  logic             alu_zero,
   output logic [UPC_W-1:0] upc,
   output logic [1:0]       alu_op,
   output logic             alu_sel_a,
   output logic [1:0]       alu_sel_b,
   output logic             ext_signed,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             iord,
   output logic             ir_wr,
   output logic             reg_wr,
   output logic             reg_dst,
   output logic             mem_to_reg,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic             pc_src,
   output logic             pc_load
);

   localparam int unsigned USED = UA_LAST + 1;

   if ((1 << UPC_W) < USED) begin : g_bad_upc
      $error("ucode_ctrl: UPC_W too narrow for the microprogram");
   end
   if (OPW < 1) begin : g_bad_opw
      $error("ucode_ctrl: OPW must be positive");
   end

   uword_t           word;
   ctrl_t            ctrl;
   logic [UPC_W-1:0] dsp_target;

   ucode_seq #(.UPC_W(UPC_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq        (word.seq),
      .dsp_target (dsp_target),
      .upc        (upc)
   );

   ucode_rom #(.UPC_W(UPC_W)) u_rom (
      .addr (upc),
      .word (word)
   );

   ucode_dispatch #(
      .OPW(OPW), .UPC_W(UPC_W), .OP_RR(OP_RR), .OP_LOAD(OP_LOAD),
      .OP_STOR(OP_STOR), .OP_BEQ(OP_BEQ), .OP_ORI(OP_ORI)
   ) u_dsp (
      .opcode (opcode),
      .target (dsp_target)
   );

   ucode_decode u_dec (
      .word (word),
      .ctrl (ctrl)
   );

   assign alu_op     = ctrl.alu_op;
   assign alu_sel_a  = ctrl.alu_sel_a;
   assign alu_sel_b  = ctrl.alu_sel_b;
   assign ext_signed = ctrl.ext_signed;
   assign mem_rd     = ctrl.mem_rd;
   assign mem_wr     = ctrl.mem_wr;
   assign iord       = ctrl.iord;
   assign ir_wr      = ctrl.ir_wr;
   assign reg_wr     = ctrl.reg_wr;
   assign reg_dst    = ctrl.reg_dst;
   assign mem_to_reg = ctrl.mem_to_reg;
   assign pc_wr      = ctrl.pc_wr;
   assign pc_wr_cond = ctrl.pc_wr_cond;
   assign pc_src     = ctrl.pc_src;
   assign pc_load    = ctrl.pc_wr | (ctrl.pc_wr_cond & alu_zero);

endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk #(
   parameter int unsigned    OPW     = 6,
   parameter int unsigned    UPC_W   = 4,
   parameter logic [OPW-1:0] OP_RR   = 6'h00,
   parameter logic [OPW-1:0] OP_LOAD = 6'h23,
   parameter logic [OPW-1:0] OP_STOR = 6'h2b,
   parameter logic [OPW-1:0] OP_BEQ  = 6'h04,
   parameter logic [OPW-1:0] OP_ORI  = 6'h0d
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OPW-1:0]   opcode,
   input logic             alu_zero,
   input logic [UPC_W-1:0] upc,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             iord,
   input logic             ir_wr,
   input logic             reg_wr,
   input logic             pc_wr,
   input logic             pc_load
);

   logic known;
   assign known = (opcode == OP_RR) || (opcode == OP_LOAD) || (opcode == OP_STOR) ||
                  (opcode == OP_BEQ) || (opcode == OP_ORI);

   p_reset_upc_r1: assert property (@(posedge clk) !rst_n |=> (rst_n || upc == '0));

   p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == '0) |=> (upc == UPC_W'(1)));

   p_fetch_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == '0) |-> (mem_rd && !iord && ir_wr && pc_wr && pc_load));

   p_dsp_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(1) && opcode == OP_LOAD) |=> (upc == UPC_W'(2)));

   p_dsp_beq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(1) && opcode == OP_BEQ) |=> (upc == UPC_W'(9)));

   p_dsp_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(1) && !known) |=> (upc == '0));

   p_load_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(4)) |=> (upc == '0));

   p_store_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(6)) |=> (upc == '0));

   p_rr_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(8)) |=> (upc == '0));

   p_beq_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(9)) |-> (pc_load == alu_zero));

   p_ori_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(11)) |=> (upc == '0));

   p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_regwr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (!mem_rd && !mem_wr && !ir_wr && !pc_load));

endmodule

bind ucode_ctrl ucode_ctrl_chk #(
   .OPW(OPW), .UPC_W(UPC_W), .OP_RR(OP_RR), .OP_LOAD(OP_LOAD),
   .OP_STOR(OP_STOR), .OP_BEQ(OP_BEQ), .OP_ORI(OP_ORI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .upc(upc),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord), .ir_wr(ir_wr),
   .reg_wr(reg_wr), .pc_wr(pc_wr), .pc_load(pc_load)
);

// File: tb/sim_ucode_ctrl.sv
module sim_ucode_ctrl;

   localparam int OPW   = 6;
   localparam int UPC_W = 4;
   localparam logic [OPW-1:0] C_RR = 6'h00, C_LD = 6'h23, C_ST = 6'h2b,
                              C_BQ = 6'h04, C_OR = 6'h0d, C_XX = 6'h3f;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [OPW-1:0] opcode = '0;
   logic alu_zero = 1'b0;
   logic [UPC_W-1:0] upc;
   logic [1:0] alu_op, alu_sel_b;
   logic alu_sel_a, ext_signed, mem_rd, mem_wr, iord, ir_wr, reg_wr, reg_dst;
   logic mem_to_reg, pc_wr, pc_wr_cond, pc_src, pc_load;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ucode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .upc(upc),
      .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
      .ext_signed(ext_signed), .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord),
      .ir_wr(ir_wr), .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .pc_load(pc_load)
   );

   typedef struct {
      logic [20:0] v;
      string       tag;
   } item_t;

   item_t sb[$];

   // packing: upc, alu_op, sel_a, sel_b, ext, then 11 control bits
   // {mem_rd, mem_wr, iord, ir_wr, reg_wr, reg_dst, mem_to_reg, pc_wr, pc_wr_cond, pc_src, pc_load}
   function automatic logic [20:0] ex(int u, logic [1:0] aop, logic sa, logic [1:0] sbv,
                                      logic ext, logic [10:0] c);
      return {4'(u), aop, sa, sbv, ext, c};
   endfunction

   function automatic logic [20:0] actual();
      return {upc, alu_op, alu_sel_a, alu_sel_b, ext_signed, mem_rd, mem_wr, iord, ir_wr,
              reg_wr, reg_dst, mem_to_reg, pc_wr, pc_wr_cond, pc_src, pc_load};
   endfunction

   localparam logic [20:0] E_FETCH  = {4'd0, 2'b00, 1'b0, 2'b00, 1'b0, 11'b100_1000_1001};
   localparam logic [20:0] E_DECODE = {4'd1, 2'b00, 1'b0, 2'b10, 1'b1, 11'b000_0000_0000};

   task automatic push(logic [20:0] v, string tag);
      item_t it;
      it.v = v;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic check_now(logic [20:0] exp, string tag);
      logic [20:0] a;
      a = actual();
      checks++;
      if (a !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, a, exp);
      end
   endtask

   // driver: called just after a rising edge while the design is at fetch
   task automatic run_op(logic [OPW-1:0] op, logic z);
      int n;
      opcode   = op;
      alu_zero = z;
      push(E_FETCH, "R2");
      push(E_DECODE, "R3");
      n = 2;
      case (op)
         C_LD: begin
            push(ex(2, 2'b00, 1, 2'b11, 1, 11'b000_0000_0000), "R5");
            push(ex(3, 2'b00, 0, 2'b00, 0, 11'b101_0000_0000), "R5");
            push(ex(4, 2'b00, 0, 2'b00, 0, 11'b000_0101_0000), "R5");
            n += 3;
         end
         C_ST: begin
            push(ex(5, 2'b00, 1, 2'b11, 1, 11'b000_0000_0000), "R6");
            push(ex(6, 2'b00, 0, 2'b00, 0, 11'b011_0000_0000), "R6");
            n += 2;
         end
         C_RR: begin
            push(ex(7, 2'b10, 1, 2'b01, 0, 11'b000_0000_0000), "R7");
            push(ex(8, 2'b00, 0, 2'b00, 0, 11'b000_0110_0000), "R7 R10");
            n += 2;
         end
         C_BQ: begin
            push(ex(9, 2'b01, 1, 2'b01, 0, {10'b000_0000_011, z}), "R8");
            n += 1;
         end
         C_OR: begin
            push(ex(10, 2'b11, 1, 2'b11, 0, 11'b000_0000_0000), "R9");
            push(ex(11, 2'b00, 0, 2'b00, 0, 11'b000_0100_0000), "R9");
            n += 2;
         end
         default: ;
      endcase
      repeat (n) @(posedge clk);
      #1;
   endtask

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check_now(it.v, it.tag);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_now(E_FETCH, "R1");
      rst_n = 1'b1;
      run_op(C_LD, 1'b0);
      run_op(C_ST, 1'b1);
      run_op(C_RR, 1'b0);
      run_op(C_BQ, 1'b1);
      run_op(C_BQ, 1'b0);
      run_op(C_OR, 1'b1);
      run_op(C_XX, 1'b0);
      check_now(E_FETCH, "R4");   // unknown opcode fell back to fetch
      run_op(C_RR, 1'b1);         // R10: zero flag must not raise pc_load here
      run_op(C_LD, 1'b1);         // R10: zero flag ignored on load steps
      run_op(C_OR, 1'b0);
      @(negedge clk);
      #1;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule